// File: doc/BRIEF.md
# Multi-mode 8x8 multiplier core

This block multiplies two byte operands and returns a 16-bit product as a high byte and a low byte. A 3-bit mode code picks how the operands are read: both unsigned, both two's complement, or the first operand two's complement and the second unsigned. A fractional option doubles the integer product so that operands in signed 1.7 fixed point (for example 0xB0 is -0.625) give a 1.15 result.

Two flags come with the product. The carry flag is the most significant bit of the integer product before any fractional doubling, which is the bit that fractional modes shift out. Wider arithmetic built from byte products uses it for sign correction. The zero flag reports an all-zero final result. Results are registered: product and flags take new values only on a clock edge where the valid strobe is high, and hold otherwise.

Top module: `mulx_core`

## Requirements
- R1: Mode 3'b000 gives the unsigned product op_a * op_b as a 16-bit value, prod_hi holding bits 15..8 and prod_lo bits 7..0.
- R2: Mode 3'b001 treats both operands as two's complement and gives the 16-bit two's complement product.
- R3: Mode 3'b010 treats op_a as two's complement and op_b as unsigned and gives the 16-bit two's complement product.
- R4: When mode bit 2 is set, the result is the integer product of the signedness chosen by mode bits 1..0, shifted left by one bit and truncated to 16 bits; bit 0 of the result is then 0.
- R5: carry equals bit 15 of the integer product before any fractional shift, in every mode.
- R6: zero is 1 exactly when the final 16-bit result {prod_hi, prod_lo} is all zeros.
- R7: Results and flags appear on the first rising clock edge at which in_valid is high, one cycle after the operands are presented; they do not change before that edge.
- R8: On an edge with in_valid low, prod_hi, prod_lo, carry and zero keep their values whatever the operand and mode inputs do.
- R9: A synchronous active-low reset sets prod_hi and prod_lo to 0, carry to 0 and zero to 1.
- R10: Mode bits 1..0 equal to 2'b11 are read as unsigned by unsigned (with or without the fractional bit).
- R11: The same byte on both operands gives its square; in mode 3'b001 two negative operands give a positive, nonzero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe that loads a new result on the next edge |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| mode | input | 3 | Bit 2 fractional, bits 1..0 signedness (00 uu, 01 ss, 10 su, 11 uu) |
| prod_hi | output | 8 | Result bits 15..8 |
| prod_lo | output | 8 | Result bits 7..0 |
| carry | output | 1 | Bit 15 of the integer product before any shift |
| zero | output | 1 | Result is all zeros |

## Verification
The operand pairs are chosen so that each signedness reading gives a different answer for the same bytes: 0xFF times 0xFF is 0xFE01 unsigned, 0x0001 signed and 0xFF01 signed by unsigned, which catches a swapped or ignored mode bit. The most negative byte squared separates correct two's complement handling from overflow, and in fractional mode it shows the shifted-out bit and the wrapped 0x8000 result. Products whose bit 15 differs from the fractional result's bit 15 tell a carry taken after the shift apart from one taken before. Zero operands in integer and fractional modes, held strobes with changing inputs, and a reset in mid-run close the set.

// File: rtl/mulx_pkg.sv
// Shared types for the multi-mode multiplier.
// Assumes mode bit 2 selects fractional output and bits 1..0 the signedness.
package mulx_pkg;
    typedef enum logic [1:0] {
        SGN_UU  = 2'b00,
        SGN_SS  = 2'b01,
        SGN_SU  = 2'b10,
        SGN_RSV = 2'b11
    } sgn_e;

    typedef struct packed {
        logic frac;
        sgn_e sgn;
    } mode_t;
endpackage

// File: rtl/mulx_operand_ext.sv
// Widens an operand by one bit so one signed multiplier serves every mode.
// Assumes signed_en selects two's complement reading of v.
module mulx_operand_ext #(
    parameter int W = 8
) (
    input  logic                v,
    input  logic [W-1:0]        val,
    output logic signed [W:0]   ext
);
    // Extension bit is the sign bit only when the operand is read as signed.
    always_comb begin
        ext = $signed({v & val[W-1], val});
    end
endmodule

// File: rtl/mulx_array.sv
// Signed multiply of two widened operands, truncated to 2*W bits.
// Assumes operands are already extended to W+1 bits by mulx_operand_ext.
module mulx_array #(
    parameter int W = 8
) (
    input  logic signed [W:0]   xa,
    input  logic signed [W:0]   xb,
    output logic [2*W-1:0]      raw
);
    // Both factors signed, so the product is sign-extended and truncated.
    always_comb begin
        raw = xa * xb;
    end
endmodule

// File: rtl/mulx_post.sv
// Applies the fractional shift and derives carry and zero flags.
// Assumes raw is the integer product of width 2*W.
module mulx_post #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] raw,
    input  logic           frac,
    output logic [2*W-1:0] res,
    output logic           cy,
    output logic           zf
);
    localparam int PW = 2 * W;

    // Doubling in fractional mode, carry taken from the unshifted product.
    always_comb begin
        res = frac ? {raw[PW-2:0], 1'b0} : raw;
        cy  = raw[PW-1];
        zf  = (res == '0);
    end
endmodule

// File: rtl/mulx_core.sv
// Multi-mode byte multiplier with registered product and flags.
// Assumes a synchronous active-low reset and a one-cycle valid strobe.
module mulx_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   mode,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         carry,
    output logic         zero
);
    import mulx_pkg::*;

    localparam int PW = 2 * W;

    mode_t            md;
    logic             a_sgn, b_sgn;
    logic signed [W:0] xa, xb;
    logic [PW-1:0]    raw, res;
    logic             cy, zf;

    // Decode signedness of each operand from the mode code.
    always_comb begin
        md    = mode_t'(mode);
        a_sgn = (md.sgn == SGN_SS) || (md.sgn == SGN_SU);
        b_sgn = (md.sgn == SGN_SS);
    end

    mulx_operand_ext #(.W(W)) u_ext_a (.v(a_sgn), .val(op_a), .ext(xa));
    mulx_operand_ext #(.W(W)) u_ext_b (.v(b_sgn), .val(op_b), .ext(xb));
    mulx_array       #(.W(W)) u_arr   (.xa(xa), .xb(xb), .raw(raw));
    mulx_post        #(.W(W)) u_post  (.raw(raw), .frac(md.frac), .res(res),
                                       .cy(cy), .zf(zf));

    // Result register: cleared on reset, loaded only on a valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_hi <= '0;
            prod_lo <= '0;
            carry   <= 1'b0;
            zero    <= 1'b1;
        end else if (in_valid) begin
            prod_hi <= res[PW-1:W];
            prod_lo <= res[W-1:0];
            carry   <= cy;
            zero    <= zf;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(prod_hi) && $stable(prod_lo) && $stable(carry) && $stable(zero)));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        zero == ({prod_hi, prod_lo} == '0));

    assert_frac_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[2]) |=> !prod_lo[0]);

    assert_unsigned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'b000) |=>
        ({prod_hi, prod_lo} == ({{W{1'b0}}, $past(op_a)} * {{W{1'b0}}, $past(op_b)})));

    assert_neg_square_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'b001 && op_a[W-1] && op_b[W-1]) |=> (!prod_hi[W-1] && !zero));
endmodule

// File: tb/mulx_core_test.sv
module mulx_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [2:0] mode = '0;
    logic [7:0] prod_hi, prod_lo;
    logic       carry, zero;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mulx_core uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .mode(mode),
        .prod_hi(prod_hi), .prod_lo(prod_lo), .carry(carry), .zero(zero)
    );

    // {op_a, op_b, mode, expected result, expected carry}
    localparam int NV = 17;
    localparam logic [35:0] VEC [0:NV-1] = '{
        {8'h05, 8'h07, 3'b000, 16'h0023, 1'b0},  // R1
        {8'hFF, 8'hFF, 3'b000, 16'hFE01, 1'b1},  // R1 R5
        {8'hFF, 8'hFF, 3'b001, 16'h0001, 1'b0},  // R2 R11
        {8'h80, 8'h80, 3'b001, 16'h4000, 1'b0},  // R2 R11
        {8'h80, 8'h01, 3'b001, 16'hFF80, 1'b1},  // R2 R5
        {8'hFF, 8'hFF, 3'b010, 16'hFF01, 1'b1},  // R3
        {8'h02, 8'h80, 3'b010, 16'h0100, 1'b0},  // R3
        {8'h80, 8'h80, 3'b100, 16'h8000, 1'b0},  // R4 R5
        {8'hFF, 8'hFF, 3'b100, 16'hFC02, 1'b1},  // R4
        {8'h40, 8'hB0, 3'b101, 16'hD800, 1'b1},  // R4
        {8'h80, 8'h80, 3'b101, 16'h8000, 1'b0},  // R4 R5
        {8'hC0, 8'h02, 3'b110, 16'hFF00, 1'b1},  // R4
        {8'hFF, 8'hFF, 3'b011, 16'hFE01, 1'b1},  // R10
        {8'h03, 8'h05, 3'b111, 16'h001E, 1'b0},  // R10
        {8'h00, 8'h9C, 3'b000, 16'h0000, 1'b0},  // R6
        {8'h00, 8'h80, 3'b101, 16'h0000, 1'b0},  // R6
        {8'hB0, 8'hB0, 3'b001, 16'h1900, 1'b0}   // R11
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [2:0] m);
        @(negedge clk);
        op_a = a; op_b = b; mode = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 product", {prod_hi, prod_lo}, 16'h0000);
        chk("R9 flags", {14'd0, carry, zero}, 16'h0001);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][35:28], VEC[i][27:20], VEC[i][19:17]);
            chk($sformatf("R1-R4 vector %0d product", i), {prod_hi, prod_lo}, VEC[i][16:1]);
            chk($sformatf("R5 vector %0d carry", i), {15'd0, carry}, {15'd0, VEC[i][0]});
            chk($sformatf("R6 vector %0d zero", i), {15'd0, zero},
                {15'd0, (VEC[i][16:1] == 16'h0000)});
        end

        // R8: inputs change with strobe low, outputs keep last vector
        @(negedge clk);
        op_a = 8'h12; op_b = 8'h34; mode = 3'b000; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 hold product", {prod_hi, prod_lo}, 16'h1900);
        chk("R8 hold flags", {14'd0, carry, zero}, 16'h0000);

        // R7: before the edge the old result stays, after it the new one shows
        @(negedge clk);
        op_a = 8'h10; op_b = 8'h10; mode = 3'b000; in_valid = 1'b1;
        #1;
        chk("R7 before edge", {prod_hi, prod_lo}, 16'h1900);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 after edge", {prod_hi, prod_lo}, 16'h0100);

        // R9: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 mid-run product", {prod_hi, prod_lo}, 16'h0000);
        chk("R9 mid-run flags", {14'd0, carry, zero}, 16'h0001);

        // R11: square of 0x81 signed is 127*127
        apply(8'h81, 8'h81, 3'b001);
        chk("R11 square", {prod_hi, prod_lo}, 16'h3F01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule